// File: doc/BRIEF.md
# Graphics Function Base Address Decoder

This block holds the two base address registers of an integrated graphics function in configuration space and decides which processor cycles that function claims. One register places a 512 KB memory window anywhere in 32-bit memory space. The other places an 8-byte register window anywhere in 16-bit I/O space. Software programs both through a small configuration port. The port takes a dword offset, a function number, byte enables and write data. Read data comes back one clock later from a register.

Processor cycles arrive on a separate set of inputs: an address, a memory/I/O flag and a size code. The block raises a memory claim or an I/O claim in the same cycle, with no register in the path. The I/O claim also depends on the I/O enable, the device power state and the fuse disable for graphics. It does not depend on any display-compatibility enable.

Top module: `gfx_bar_decode`

## Requirements
- R1: After reset the memory BAR (dword offset 5, byte offset 14h) reads 00000000h and the I/O BAR (dword offset 6, byte offset 18h) reads 00000001h.
- R2: In the memory BAR only bits 31:19 are writable. Bits 18:0 always read 0, which covers the window-size bits, prefetch bit 3, type bits 2:1 and space bit 0.
- R3: In the I/O BAR only bits 15:3 are writable. Bits 31:16 and 2:1 read 0 and bit 0 always reads 1.
- R4: A config write changes only the bytes whose enable bit is 1 (cfg_be[n] covers data bits 8n+7:8n). A write with cfg_be = 0 changes nothing.
- R5: Config reads of any dword offset other than 5 and 6 return 0. Config writes to those offsets change neither BAR.
- R6: A config access whose cfg_func is not 0 reads 0 and writes nothing, even at offset 5 or 6.
- R7: cfg_rdata shows the register selected on the previous clock edge. A write takes effect at the edge where cfg_we is sampled, so a read of the same offset issued in that cycle still returns the old value.
- R8: mem_hit is high in the same cycle when cyc_valid=1, cyc_is_io=0 and cyc_addr[31:19] equals memory BAR bits 31:19.
- R9: io_hit requires all of the following: cyc_valid=1, cyc_is_io=1, cyc_addr[31:16]=0, cyc_addr[15:3] equal to I/O BAR bits 15:3, and cyc_size one of 0 (byte), 1 (word) or 2 (dword). Size code 3 is never claimed.
- R10: io_hit stays low while io_en=0, dev_on=0 or fuse_dis=1, whatever the address.
- R11: mem_hit and io_hit are never high together, and both stay low while cyc_valid=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Config write strobe |
| cfg_func | input | 3 | Config function number |
| cfg_dw_off | input | 6 | Config dword offset |
| cfg_be | input | 4 | Config byte enables |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Registered config read data |
| cyc_valid | input | 1 | Processor cycle present |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_addr | input | 32 | Processor cycle address |
| cyc_size | input | 2 | Cycle size code: 0 byte, 1 word, 2 dword, 3 reserved |
| io_en | input | 1 | I/O space enable from the command register |
| dev_on | input | 1 | Device powered on |
| fuse_dis | input | 1 | Graphics disabled by fuse |
| mem_hit | output | 1 | Memory window claim |
| io_hit | output | 1 | I/O window claim |

## Verification
The assertions run on every cycle. They check that the read-only bits of each BAR come back at their fixed values whenever that BAR is read. They check that a read from a nonzero function or an unused offset returns zero. They also check that a register stays unchanged when there is no write or when the byte enable for that byte is low, that an I/O claim never appears while the gating inputs forbid it, and that the two claims never occur together.

Only the bench scenarios can show that claims are correct as a function of the programmed bases. They cover the window edges, addresses just outside each window, I/O addresses with nonzero upper bits, and the reserved size code. The bench also shows partial byte-enable merges and the one-cycle lag between a write and a read of the same offset.

// File: rtl/gfx_bar_pkg.sv
package gfx_bar_pkg;
  localparam int CFG_DW_W = 6;
  localparam int FUNC_W   = 3;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } cyc_size_e;
endpackage

// File: rtl/gfx_bar_reg.sv
module gfx_bar_reg #(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] WR_MASK = 32'hFFF8_0000,
  parameter logic [31:0] FIXED   = 32'h0000_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   value
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_be[b]) q[8*b +: 8] <= wr_data[8*b +: 8] & WR_MASK[8*b +: 8];
      end
    end
  end

  assign value = q | FIXED[DATA_W-1:0];

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(value)); // R5

  for (genvar g = 0; g < NBYTES; g++) begin : g_be_chk
    AST_BYTE_MASKED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_be[g]) |=> $stable(value[8*g +: 8])); // R4
  end
endmodule

// File: rtl/gfx_bar_match.sv
module gfx_bar_match #(
  parameter int ADDR_W  = 32,
  parameter int WIN_LSB = 19,
  parameter int SPACE_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam int CMP_MSB = SPACE_W - 1;

  logic base_eq;
  logic upper_zero;

  assign base_eq = (addr[CMP_MSB:WIN_LSB] == base[CMP_MSB:WIN_LSB]);

  if (SPACE_W < ADDR_W) begin : g_narrow_space
    assign upper_zero = (addr[ADDR_W-1:SPACE_W] == '0);
    logic unused_base_hi;
    assign unused_base_hi = &{1'b0, base[ADDR_W-1:SPACE_W]};
  end else begin : g_full_space
    assign upper_zero = 1'b1;
  end

  logic unused_low;
  assign unused_low = &{1'b0, addr[WIN_LSB-1:0], base[WIN_LSB-1:0]};

  assign hit = base_eq & upper_zero;
endmodule

// File: rtl/gfx_bar_rdmux.sv
module gfx_bar_rdmux #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_mem,
  input  logic              sel_io,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] io_val,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (sel_mem) rdata <= mem_val;
    else if (sel_io)  rdata <= io_val;
    else              rdata <= '0;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!sel_mem && !sel_io) |=> (rdata == '0)); // R5
endmodule

// File: rtl/gfx_bar_decode.sv
module gfx_bar_decode
  import gfx_bar_pkg::*;
#(
  parameter int                  ADDR_W       = 32,
  parameter int                  MEM_WIN_LOG2 = 19,
  parameter int                  IO_WIN_LOG2  = 3,
  parameter int                  IO_SPACE_W   = 16,
  parameter logic [CFG_DW_W-1:0] MEM_DW       = 6'd5,
  parameter logic [CFG_DW_W-1:0] IO_DW        = 6'd6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [FUNC_W-1:0]   cfg_func,
  input  logic [CFG_DW_W-1:0] cfg_dw_off,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                cyc_valid,
  input  logic                cyc_is_io,
  input  logic [ADDR_W-1:0]   cyc_addr,
  input  logic [1:0]          cyc_size,
  input  logic                io_en,
  input  logic                dev_on,
  input  logic                fuse_dis,
  output logic                mem_hit,
  output logic                io_hit
);
  localparam logic [31:0] ONES      = 32'hFFFF_FFFF;
  localparam logic [31:0] MEM_WMASK = ONES << MEM_WIN_LOG2;
  localparam logic [31:0] IO_WMASK  = (ONES << IO_WIN_LOG2) & ~(ONES << IO_SPACE_W);
  localparam logic [31:0] MEM_FIXED = 32'h0000_0000;
  localparam logic [31:0] IO_FIXED  = 32'h0000_0001;

  logic        fn0;
  logic        sel_mem, sel_io;
  logic [31:0] mem_bar, io_bar;
  logic        mem_match, io_match;
  logic        io_allowed, size_ok;

  assign fn0     = (cfg_func == '0);
  assign sel_mem = fn0 && (cfg_dw_off == MEM_DW);
  assign sel_io  = fn0 && (cfg_dw_off == IO_DW);

  gfx_bar_reg #(.DATA_W(32), .WR_MASK(MEM_WMASK), .FIXED(MEM_FIXED)) i_mem_bar (
    .clk(clk), .rst(rst), .wr_en(cfg_we && sel_mem), .wr_be(cfg_be),
    .wr_data(cfg_wdata), .value(mem_bar));

  gfx_bar_reg #(.DATA_W(32), .WR_MASK(IO_WMASK), .FIXED(IO_FIXED)) i_io_bar (
    .clk(clk), .rst(rst), .wr_en(cfg_we && sel_io), .wr_be(cfg_be),
    .wr_data(cfg_wdata), .value(io_bar));

  gfx_bar_rdmux #(.DATA_W(32)) i_rdmux (
    .clk(clk), .rst(rst), .sel_mem(sel_mem), .sel_io(sel_io),
    .mem_val(mem_bar), .io_val(io_bar), .rdata(cfg_rdata));

  gfx_bar_match #(.ADDR_W(ADDR_W), .WIN_LSB(MEM_WIN_LOG2), .SPACE_W(ADDR_W)) i_mem_match (
    .addr(cyc_addr), .base(mem_bar), .hit(mem_match));

  gfx_bar_match #(.ADDR_W(ADDR_W), .WIN_LSB(IO_WIN_LOG2), .SPACE_W(IO_SPACE_W)) i_io_match (
    .addr(cyc_addr), .base(io_bar), .hit(io_match));

  assign io_allowed = io_en && dev_on && !fuse_dis;
  assign size_ok    = (cyc_size != SZ_RSVD);

  assign mem_hit = cyc_valid && !cyc_is_io && mem_match;
  assign io_hit  = cyc_valid && cyc_is_io && size_ok && io_allowed && io_match;

  AST_MEM_RO_BITS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && sel_mem) |-> (cfg_rdata[MEM_WIN_LOG2-1:0] == '0)); // R2

  AST_IO_RO_BITS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && sel_io) |-> (cfg_rdata[31:IO_SPACE_W] == '0 &&
                               cfg_rdata[2:1] == 2'b00 && cfg_rdata[0])); // R3

  AST_OTHER_FUNC_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg_func != '0) |-> (cfg_rdata == '0)); // R6

  AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
    io_hit |-> (io_en && dev_on && !fuse_dis)); // R10

  AST_HIT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_hit && io_hit)); // R11

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid |-> (!mem_hit && !io_hit)); // R11
endmodule

// File: tb/test_gfx_bar_decode.sv
module test_gfx_bar_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_func = '0;
  logic [5:0]  cfg_dw_off = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cyc_valid = 1'b0;
  logic        cyc_is_io = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [1:0]  cyc_size = '0;
  logic        io_en = 1'b1;
  logic        dev_on = 1'b1;
  logic        fuse_dis = 1'b0;
  logic        mem_hit, io_hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gfx_bar_decode i_gfx_bar_decode (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_func(cfg_func),
    .cfg_dw_off(cfg_dw_off), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid), .cyc_is_io(cyc_is_io),
    .cyc_addr(cyc_addr), .cyc_size(cyc_size), .io_en(io_en), .dev_on(dev_on),
    .fuse_dis(fuse_dis), .mem_hit(mem_hit), .io_hit(io_hit));

  task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic check1(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] fn, input logic [5:0] off,
                           input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_func = fn; cfg_dw_off = off; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [2:0] fn, input logic [5:0] off, output logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b0; cfg_func = fn; cfg_dw_off = off;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  // entry: [39] is_io, [38:7] addr, [6:5] size, [4] io_en, [3] dev_on, [2] fuse_dis, [1] exp_mem, [0] exp_io
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 32'hE008_0000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 32'hE00F_FFFC, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 32'hE010_0000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 32'hE007_FFFF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 32'h0000_1238, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 32'h0000_123C, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 32'h0000_123E, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 32'h0000_1240, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 32'h0000_1237, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 32'h0001_1238, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 32'h0000_1238, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 32'h0000_1238, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 32'h0000_1238, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 32'h0000_1238, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 32'hE008_0000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    cfg_read(3'd0, 6'd5, rd); check32("R1 memory BAR reset", rd, 32'h0000_0000);
    cfg_read(3'd0, 6'd6, rd); check32("R1 I/O BAR reset", rd, 32'h0000_0001);

    cfg_write(3'd0, 6'd5, 4'hF, 32'hFFFF_FFFF);
    cfg_read(3'd0, 6'd5, rd); check32("R2 memory BAR all ones", rd, 32'hFFF8_0000);
    cfg_write(3'd0, 6'd6, 4'hF, 32'hFFFF_FFFF);
    cfg_read(3'd0, 6'd6, rd); check32("R3 I/O BAR all ones", rd, 32'h0000_FFF9);

    cfg_write(3'd0, 6'd5, 4'b1000, 32'hE000_0000);
    cfg_read(3'd0, 6'd5, rd); check32("R4 byte 3 only", rd, 32'hE0F8_0000);
    cfg_write(3'd0, 6'd5, 4'b0100, 32'h1108_0000);
    cfg_read(3'd0, 6'd5, rd); check32("R4 byte 2 only", rd, 32'hE008_0000);
    cfg_write(3'd0, 6'd6, 4'b0011, 32'hAAAA_1238);
    cfg_read(3'd0, 6'd6, rd); check32("R4 low bytes of I/O BAR", rd, 32'h0000_1239);
    cfg_write(3'd0, 6'd5, 4'b0000, 32'h0000_0000);
    cfg_read(3'd0, 6'd5, rd); check32("R4 no byte enables", rd, 32'hE008_0000);

    cfg_write(3'd0, 6'd7, 4'hF, 32'hFFFF_FFFF);
    cfg_write(3'd0, 6'd4, 4'hF, 32'h0000_0000);
    cfg_read(3'd0, 6'd7, rd); check32("R5 unused offset reads zero", rd, 32'h0);
    cfg_read(3'd0, 6'd5, rd); check32("R5 memory BAR untouched", rd, 32'hE008_0000);
    cfg_read(3'd0, 6'd6, rd); check32("R5 I/O BAR untouched", rd, 32'h0000_1239);

    cfg_write(3'd1, 6'd5, 4'hF, 32'h0000_0000);
    cfg_write(3'd2, 6'd6, 4'hF, 32'h0000_0000);
    cfg_read(3'd1, 6'd5, rd); check32("R6 other function reads zero", rd, 32'h0);
    cfg_read(3'd0, 6'd5, rd); check32("R6 memory BAR unchanged", rd, 32'hE008_0000);
    cfg_read(3'd0, 6'd6, rd); check32("R6 I/O BAR unchanged", rd, 32'h0000_1239);

    // R7: read and write the same offset in one cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_func = 3'd0; cfg_dw_off = 6'd5; cfg_be = 4'hF; cfg_wdata = 32'hA000_0000;
    @(negedge clk);
    check32("R7 same-cycle read returns old value", cfg_rdata, 32'hE008_0000);
    cfg_we = 1'b0; cfg_be = '0;
    @(negedge clk);
    check32("R7 next read returns new value", cfg_rdata, 32'hA000_0000);
    cfg_write(3'd0, 6'd5, 4'hF, 32'hE008_0000);

    // claim table: memory base E0080000h, I/O base 1238h
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      @(negedge clk);
      cyc_valid = 1'b1; cyc_is_io = v[39]; cyc_addr = v[38:7]; cyc_size = v[6:5];
      io_en = v[4]; dev_on = v[3]; fuse_dis = v[2];
      #1;
      check1($sformatf("R8 vector %0d mem_hit", i), mem_hit, v[1]);
      check1($sformatf("R9 R10 vector %0d io_hit", i), io_hit, v[0]);
    end

    // R11: no cycle present, addresses that would match
    @(negedge clk);
    io_en = 1'b1; dev_on = 1'b1; fuse_dis = 1'b0;
    cyc_valid = 1'b0; cyc_is_io = 1'b0; cyc_addr = 32'hE008_0000; cyc_size = 2'd2;
    #1; check1("R11 idle memory mem_hit", mem_hit, 1'b0);
    cyc_is_io = 1'b1; cyc_addr = 32'h0000_1238;
    #1; check1("R11 idle I/O io_hit", io_hit, 1'b0);
    cyc_valid = 1'b1;
    #1; check1("R11 active I/O claim", io_hit, 1'b1);
    check1("R11 mem_hit low during I/O claim", mem_hit, 1'b0);

    // R10: fuse disable alone suppresses the claim
    fuse_dis = 1'b1;
    #1; check1("R10 fuse disable", io_hit, 1'b0);
    fuse_dis = 1'b0;

    // R1: a second reset restores both defaults
    @(negedge clk); cyc_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    cfg_read(3'd0, 6'd5, rd); check32("R1 memory BAR after reset", rd, 32'h0);
    cfg_read(3'd0, 6'd6, rd); check32("R1 I/O BAR after reset", rd, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule